// File: doc/BRIEF.md
# Pointer-Register Address Generation Unit

This block turns one of three 16-bit pointers into a memory byte address for a small processor core. Each pointer is a pair of 8-bit general registers. The block keeps its own copy of those six registers, and the register file's write port keeps that copy current. For each request the block takes an access mode, a pointer select and a 6-bit unsigned displacement. One clock later it returns four things:
- the effective data address;
- for program-memory reads, a 16-bit word address and a byte-lane select;
- the updated pointer, with a single write-back strobe and the index of the pair's low register;
- a flag for requests that are not allowed.

There are six modes. Plain, pre-decrement, post-increment and displacement serve data memory. The other two read program memory byte by byte, with or without a post-increment. Every update is applied to the internal pointer copy at the same edge that presents the result. A request in the next cycle therefore already sees the new pointer value.

Top module: `ptr_agu`

## Requirements
- R1: During and directly after reset, every output is 0 and all three pointers read as 0x0000.
- R2: A register-file write updates the pointer copy only for indices 26..31. The pairs are pointer 0 = {r27,r26}, pointer 1 = {r29,r28} and pointer 2 = {r31,r30}, with the odd index as the high byte. Writes to any other index leave every pointer unchanged.
- R3: Mode 0 (plain) gives effAddr = pointer and dataValid = 1, with no write-back.
- R4: Mode 1 (pre-decrement) gives effAddr = pointer - 1. It also writes back pointer - 1, with ptrWbValid = 1 and ptrWbRegLo = 26 + 2*pointer select.
- R5: Mode 2 (post-increment) gives effAddr = pointer and writes back pointer + 1.
- R6: Mode 3 (displacement) is legal with pointers 1 and 2 only. It gives effAddr = pointer + zero-extended reqDisp (0..63) and leaves the pointer unchanged.
- R7: Mode 4 (program read) is legal with pointer 2 only. It gives progValid = 1, progWordAddr = pointer[15:1], progByteHigh = pointer[0] (1 = high byte) and effAddr = pointer, with no write-back.
- R8: Mode 5 (program read, post-increment) gives the same outputs as mode 4 and also writes back pointer + 1 over the full 16 bits.
- R9: An illegal request raises reqIllegal for one cycle and asserts no valid or write-back output. Illegal requests are mode 3 with pointer 0, mode 4 or 5 with a pointer other than 2, pointer select 3, and modes 6 and 7.
- R10: Results appear exactly one cycle after the request. While no access is being presented, all address and write-back outputs are 0. Back-to-back requests each see the pointer left by the request before them.
- R11: If a pointer update and a register-file write hit the same pair in the same cycle, the update wins for both bytes. A write to a different pair in that cycle still takes effect.
- R12: Increment, decrement and displacement wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 3 | Access mode, 0..5 legal |
| reqPtr | input | 2 | Pointer select, 0..2 |
| reqDisp | input | 6 | Unsigned displacement for mode 3 |
| regWrEn | input | 1 | Register-file write strobe |
| regWrIdx | input | 5 | Register-file write index |
| regWrData | input | 8 | Register-file write data |
| dataValid | output | 1 | Data-memory address valid |
| effAddr | output | 16 | Effective byte address |
| progValid | output | 1 | Program-memory read valid |
| progWordAddr | output | 15 | Program-memory word address |
| progByteHigh | output | 1 | 1 selects the high byte of the word |
| ptrWbValid | output | 1 | Updated pointer write-back strobe |
| ptrWbRegLo | output | 5 | Register index of the pair's low byte |
| ptrWbValue | output | 16 | Updated pointer value |
| reqIllegal | output | 1 | Request was not allowed |

## Verification
A corrupted pointer copy does not stay hidden. It shows at the ports on the very next access through that pointer, as a wrong effective address or wrong write-back value, one cycle after the request. A lost or misdirected update shows up as an address that is off by one on the following back-to-back request. A wrong priority between the register-file write and the pointer update shows up in the first plain read after the collision. The bench compares every output against a behavioural register-file model on every clock, so any such divergence is caught in the cycle it first reaches a port.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  typedef enum logic [2:0] {
    MODE_PLAIN   = 3'd0,
    MODE_PREDEC  = 3'd1,
    MODE_POSTINC = 3'd2,
    MODE_DISP    = 3'd3,
    MODE_PROG    = 3'd4,
    MODE_PROGINC = 3'd5
  } agu_mode_e;

  localparam int PTR_LOW_ONLY = 0;  // pointer without displacement support
  localparam int PTR_PROG     = 2;  // only pointer allowed for program reads

  typedef struct packed {
    logic dataAcc;
    logic progAcc;
    logic useDec;
    logic useInc;
    logic useDisp;
    logic writeBack;
    logic illegal;
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import ptr_agu_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2,
  parameter int MODE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [SEL_W-1:0]  reqPtr,
  output agu_strobe_t       strobe
);

  logic ptrLegal;
  logic ptrHasDisp;
  logic ptrIsProg;

  assign ptrLegal   = (int'(reqPtr) < NUM_PTR);
  assign ptrHasDisp = ptrLegal && (int'(reqPtr) != PTR_LOW_ONLY);
  assign ptrIsProg  = (int'(reqPtr) == PTR_PROG);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      if (!ptrLegal) begin
        strobe.illegal = 1'b1;
      end else begin
        case (reqMode)
          MODE_PLAIN: strobe.dataAcc = 1'b1;
          MODE_PREDEC: begin
            strobe.dataAcc   = 1'b1;
            strobe.useDec    = 1'b1;
            strobe.writeBack = 1'b1;
          end
          MODE_POSTINC: begin
            strobe.dataAcc   = 1'b1;
            strobe.useInc    = 1'b1;
            strobe.writeBack = 1'b1;
          end
          MODE_DISP: begin
            if (ptrHasDisp) begin
              strobe.dataAcc = 1'b1;
              strobe.useDisp = 1'b1;
            end else begin
              strobe.illegal = 1'b1;
            end
          end
          MODE_PROG: begin
            if (ptrIsProg) strobe.progAcc = 1'b1;
            else           strobe.illegal = 1'b1;
          end
          MODE_PROGINC: begin
            if (ptrIsProg) begin
              strobe.progAcc   = 1'b1;
              strobe.useInc    = 1'b1;
              strobe.writeBack = 1'b1;
            end else begin
              strobe.illegal = 1'b1;
            end
          end
          default: strobe.illegal = 1'b1;
        endcase
      end
    end
  end

  AST_DISP_NEEDS_YZ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.useDisp |-> (int'(reqPtr) != PTR_LOW_ONLY)); // R6
  AST_PROG_NEEDS_Z: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progAcc |-> (int'(reqPtr) == PTR_PROG)); // R7
  AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.useDec, strobe.useInc, strobe.useDisp})); // R4
  AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |-> !(strobe.dataAcc || strobe.progAcc || strobe.writeBack)); // R9

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import ptr_agu_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int DISP_W   = 6,
  parameter int IDX_W    = 5,
  parameter int BASE_REG = 26,
  parameter int NUM_PTR  = 3,
  parameter int SEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  agu_strobe_t          strobe,
  input  logic [SEL_W-1:0]     ptrSel,
  input  logic [DISP_W-1:0]    disp,
  input  logic                 regWrEn,
  input  logic [IDX_W-1:0]     regWrIdx,
  input  logic [REG_W-1:0]     regWrData,
  output logic                 dataValid,
  output logic [2*REG_W-1:0]   effAddr,
  output logic                 progValid,
  output logic [2*REG_W-2:0]   progWordAddr,
  output logic                 progByteHigh,
  output logic                 ptrWbValid,
  output logic [IDX_W-1:0]     ptrWbRegLo,
  output logic [2*REG_W-1:0]   ptrWbValue,
  output logic                 reqIllegal
);

  localparam int ADDR_W = 2 * REG_W;

  logic [REG_W-1:0]  loByte [NUM_PTR];
  logic [REG_W-1:0]  hiByte [NUM_PTR];
  logic [ADDR_W-1:0] ptrVal;
  logic [ADDR_W-1:0] ptrDec;
  logic [ADDR_W-1:0] ptrInc;
  logic [ADDR_W-1:0] ptrDisp;
  logic [ADDR_W-1:0] effNext;
  logic [ADDR_W-1:0] wbNext;
  logic [IDX_W-1:0]  pairLoIdx;

  always_comb begin
    ptrVal = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (ptrSel == SEL_W'(i)) ptrVal = {hiByte[i], loByte[i]};
    end
  end

  assign ptrDec    = ptrVal - ADDR_W'(1);
  assign ptrInc    = ptrVal + ADDR_W'(1);
  assign ptrDisp   = ptrVal + ADDR_W'(disp);
  assign effNext   = strobe.useDec ? ptrDec : (strobe.useDisp ? ptrDisp : ptrVal);
  assign wbNext    = strobe.useDec ? ptrDec : ptrInc;
  assign pairLoIdx = IDX_W'(BASE_REG) + IDX_W'({ptrSel, 1'b0});

  // Pointer copy: register-file writes first, own update overrides the pair.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PTR; i++) begin
        loByte[i] <= '0;
        hiByte[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PTR; i++) begin
        if (regWrEn && (regWrIdx == IDX_W'(BASE_REG + 2 * i)))     loByte[i] <= regWrData;
        if (regWrEn && (regWrIdx == IDX_W'(BASE_REG + 2 * i + 1))) hiByte[i] <= regWrData;
        if (strobe.writeBack && (ptrSel == SEL_W'(i))) begin
          hiByte[i] <= wbNext[ADDR_W-1:REG_W];
          loByte[i] <= wbNext[REG_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid    <= 1'b0;
      effAddr      <= '0;
      progValid    <= 1'b0;
      progWordAddr <= '0;
      progByteHigh <= 1'b0;
      ptrWbValid   <= 1'b0;
      ptrWbRegLo   <= '0;
      ptrWbValue   <= '0;
      reqIllegal   <= 1'b0;
    end else begin
      dataValid    <= strobe.dataAcc;
      effAddr      <= (strobe.dataAcc || strobe.progAcc) ? effNext : '0;
      progValid    <= strobe.progAcc;
      progWordAddr <= strobe.progAcc ? ptrVal[ADDR_W-1:1] : '0;
      progByteHigh <= strobe.progAcc && ptrVal[0];
      ptrWbValid   <= strobe.writeBack;
      ptrWbRegLo   <= strobe.writeBack ? pairLoIdx : '0;
      ptrWbValue   <= strobe.writeBack ? wbNext : '0;
      reqIllegal   <= strobe.illegal;
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqIllegal |-> !(dataValid || progValid || ptrWbValid)); // R9
  AST_PROG_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    progValid |-> ({progWordAddr, progByteHigh} == effAddr)); // R7
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ptrWbValid |-> ((ptrWbValue == effAddr) || (ptrWbValue == effAddr + ADDR_W'(1)))); // R5
  AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    ptrWbValid |-> (ptrWbRegLo >= IDX_W'(BASE_REG) && !ptrWbRegLo[0])); // R11
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValid && progValid)); // R10

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int DISP_W   = 6,
  parameter int IDX_W    = 5,
  parameter int BASE_REG = 26,
  parameter int NUM_PTR  = 3,
  parameter int MODE_W   = 3,
  parameter int SEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [MODE_W-1:0]    reqMode,
  input  logic [SEL_W-1:0]     reqPtr,
  input  logic [DISP_W-1:0]    reqDisp,
  input  logic                 regWrEn,
  input  logic [IDX_W-1:0]     regWrIdx,
  input  logic [REG_W-1:0]     regWrData,
  output logic                 dataValid,
  output logic [2*REG_W-1:0]   effAddr,
  output logic                 progValid,
  output logic [2*REG_W-2:0]   progWordAddr,
  output logic                 progByteHigh,
  output logic                 ptrWbValid,
  output logic [IDX_W-1:0]     ptrWbRegLo,
  output logic [2*REG_W-1:0]   ptrWbValue,
  output logic                 reqIllegal
);

  agu_strobe_t strobe;

  agu_ctrl #(
    .NUM_PTR (NUM_PTR),
    .SEL_W   (SEL_W),
    .MODE_W  (MODE_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .reqPtr   (reqPtr),
    .strobe   (strobe)
  );

  agu_datapath #(
    .REG_W    (REG_W),
    .DISP_W   (DISP_W),
    .IDX_W    (IDX_W),
    .BASE_REG (BASE_REG),
    .NUM_PTR  (NUM_PTR),
    .SEL_W    (SEL_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ptrSel       (reqPtr),
    .disp         (reqDisp),
    .regWrEn      (regWrEn),
    .regWrIdx     (regWrIdx),
    .regWrData    (regWrData),
    .dataValid    (dataValid),
    .effAddr      (effAddr),
    .progValid    (progValid),
    .progWordAddr (progWordAddr),
    .progByteHigh (progByteHigh),
    .ptrWbValid   (ptrWbValid),
    .ptrWbRegLo   (ptrWbRegLo),
    .ptrWbValue   (ptrWbValue),
    .reqIllegal   (reqIllegal)
  );

endmodule

// File: tb/ptr_agu_tb.sv
module ptr_agu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [1:0]  reqPtr = '0;
  logic [5:0]  reqDisp = '0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regWrIdx = '0;
  logic [7:0]  regWrData = '0;
  logic        dataValid;
  logic [15:0] effAddr;
  logic        progValid;
  logic [14:0] progWordAddr;
  logic        progByteHigh;
  logic        ptrWbValid;
  logic [4:0]  ptrWbRegLo;
  logic [15:0] ptrWbValue;
  logic        reqIllegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int rf [32];
  logic [56:0] expVec = '0;
  string expTag = "R1";

  always #5 clk = ~clk;

  ptr_agu dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqPtr(reqPtr), .reqDisp(reqDisp), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData), .dataValid(dataValid),
    .effAddr(effAddr), .progValid(progValid), .progWordAddr(progWordAddr),
    .progByteHigh(progByteHigh), .ptrWbValid(ptrWbValid),
    .ptrWbRegLo(ptrWbRegLo), .ptrWbValue(ptrWbValue), .reqIllegal(reqIllegal)
  );

  function automatic logic [56:0] actual();
    return {dataValid, effAddr, progValid, progWordAddr, progByteHigh,
            ptrWbValid, ptrWbRegLo, ptrWbValue, reqIllegal};
  endfunction

  task automatic compare();
    checks++;
    if (actual() !== expVec) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", expTag, actual(), expVec);
    end
  endtask

  // One clock: check what the previous request produced, then drive a new one
  // and predict its result from the behavioural register-file model.
  task automatic cyc(input bit v, input int mode, input int ptr, input int q,
                     input bit we, input int idx, input int data, input string tag);
    int p, eff, wbv, lo;
    bit dv, pv, wb, ill;
    @(negedge clk);
    compare();
    reqValid = v; reqMode = 3'(mode); reqPtr = 2'(ptr); reqDisp = 6'(q);
    regWrEn = we; regWrIdx = 5'(idx); regWrData = 8'(data);
    dv = 0; pv = 0; wb = 0; ill = 0; eff = 0; wbv = 0; lo = 0;
    p = 0;
    if (ptr < 3) p = rf[27 + 2*ptr] * 256 + rf[26 + 2*ptr];
    if (v) begin
      if (ptr > 2) ill = 1;
      else if (mode == 0) begin dv = 1; eff = p; end
      else if (mode == 1) begin dv = 1; eff = (p + 65535) % 65536; wb = 1; wbv = eff; end
      else if (mode == 2) begin dv = 1; eff = p; wb = 1; wbv = (p + 1) % 65536; end
      else if (mode == 3) begin
        if (ptr == 0) ill = 1; else begin dv = 1; eff = (p + q) % 65536; end
      end
      else if (mode == 4 || mode == 5) begin
        if (ptr != 2) ill = 1;
        else begin
          pv = 1; eff = p;
          if (mode == 5) begin wb = 1; wbv = (p + 1) % 65536; end
        end
      end
      else ill = 1;
    end
    if (wb) lo = 26 + 2*ptr;
    expVec = {dv, 16'(eff), pv, pv ? 15'(eff / 2) : 15'(0), pv && (eff % 2 == 1),
              wb, 5'(lo), 16'(wbv), ill};
    expTag = tag;
    if (we) rf[idx] = data;
    if (wb) begin rf[lo] = wbv % 256; rf[lo + 1] = wbv / 256; end
  endtask

  task automatic setPtr(input int ptr, input int val, input string tag);
    cyc(0, 0, 0, 0, 1, 26 + 2*ptr, val % 256, tag);
    cyc(0, 0, 0, 0, 1, 27 + 2*ptr, val / 256, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                                  // R1: outputs zero in reset
    rstN = 1'b1;
    cyc(1, 0, 0, 0, 0, 0, 0, "R1");             // R1: pointers read 0 after reset
    cyc(1, 0, 2, 0, 0, 0, 0, "R1");
    setPtr(0, 16'h1234, "R2");
    setPtr(1, 16'h00FF, "R2");
    setPtr(2, 16'h3A21, "R2");
    cyc(0, 0, 0, 0, 1, 5, 8'h77, "R2");         // R2: index outside 26..31
    cyc(0, 0, 0, 0, 1, 25, 8'h66, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, "R3");             // R3 plain X (also R2 readback)
    cyc(1, 0, 1, 0, 0, 0, 0, "R3");
    cyc(1, 1, 0, 0, 0, 0, 0, "R4");             // R4 pre-decrement
    cyc(1, 2, 0, 0, 0, 0, 0, "R5");             // R5 post-increment, R10 back-to-back
    cyc(1, 2, 1, 0, 0, 0, 0, "R10");
    cyc(1, 2, 1, 0, 0, 0, 0, "R10");
    cyc(1, 0, 1, 0, 0, 0, 0, "R10");
    cyc(1, 3, 1, 63, 0, 0, 0, "R6");            // R6 displacement
    cyc(1, 3, 2, 0, 0, 0, 0, "R6");
    cyc(1, 3, 2, 29, 0, 0, 0, "R6");
    cyc(1, 4, 2, 0, 0, 0, 0, "R7");             // R7 program read, high byte
    cyc(1, 5, 2, 0, 0, 0, 0, "R8");             // R8 with post-increment
    cyc(1, 4, 2, 0, 0, 0, 0, "R8");             // low byte now
    cyc(1, 5, 2, 0, 0, 0, 0, "R8");
    cyc(1, 3, 0, 5, 0, 0, 0, "R9");             // R9 illegal cases
    cyc(1, 4, 1, 0, 0, 0, 0, "R9");
    cyc(1, 5, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 3, 0, 0, 0, 0, "R9");
    cyc(1, 6, 1, 0, 0, 0, 0, "R9");
    cyc(1, 7, 2, 0, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, 0, "R9");             // pointer unchanged by illegal
    setPtr(1, 16'hFFFF, "R12");
    cyc(1, 2, 1, 0, 0, 0, 0, "R12");            // R12 increment wraps
    cyc(1, 0, 1, 0, 0, 0, 0, "R12");
    setPtr(0, 16'h0000, "R12");
    cyc(1, 1, 0, 0, 0, 0, 0, "R12");            // decrement wraps
    setPtr(2, 16'hFFC1, "R12");
    cyc(1, 3, 2, 63, 0, 0, 0, "R12");           // displacement wraps
    cyc(1, 5, 2, 0, 1, 30, 8'hAA, "R11");       // R11 update beats write
    cyc(1, 0, 2, 0, 0, 0, 0, "R11");
    cyc(1, 2, 2, 0, 1, 31, 8'h55, "R11");
    cyc(1, 0, 2, 0, 0, 0, 0, "R11");
    cyc(1, 1, 2, 0, 1, 26, 8'h9C, "R11");       // other pair write still lands
    cyc(1, 0, 0, 0, 0, 0, 0, "R11");
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");            // idle: outputs return to 0
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule